// File: doc/BRIEF.md
# HDLC Test and Loopback Router

This block sits between the host port of an HDLC controller, its receive and transmit FIFOs, its framers and the serial line. It holds a small test-control register and steers data according to the modes selected there. The block never stores payload. It only decides which source drives each FIFO write, which consumer drives each FIFO read, what the host sees on reads, and which bit feeds the serial receiver.

Four modes are available. Receive-to-transmit loopback copies every byte the receiver delivers into the TX FIFO as well as the RX FIFO. Transmit-to-receive loopback feeds the serial transmit bit back into the receiver. FIFO test swap turns a host TX write into an RX FIFO write and a host RX read into a TX FIFO read, so both FIFOs can be exercised from the host alone. A sticky soft reset holds the rest of the controller in reset. It is set by one write but needs a run of consecutive zero writes to clear.

Top module: `hdlc_tst_router`

## Requirements
- R1: After the hardware reset is released, the control readback is all zero, `soft_rst_o` is low and every steering mode is off.
- R2: A control write with bit 0 set and the reserved field zero raises `soft_rst_o` in the following cycle and clears all mode bits. While `soft_rst_o` is high, no FIFO write or read strobe is issued, the mode bits stay zero, and `rx_ser_o` follows `line_rx_i`.
- R3: `soft_rst_o` clears only on the ZERO_WRITES-th consecutive accepted control write with bit 0 at zero (default 2). Idle cycles do not break the run. An accepted write with bit 0 set restarts the count. Only the hardware reset clears it otherwise.
- R4: Control bits 7:4 are reserved. They always read as zero, and a write with any of them set is dropped entirely.
- R5: Control layout: bit 1 is receive-to-transmit loopback, bit 2 is transmit-to-receive loopback and bit 3 is FIFO swap. Mode bits take the written value only on an accepted write with bit 0 at zero while the soft reset is low.
- R6: With no mode set, receiver bytes and tags go to the RX FIFO, host TX writes go to the TX FIFO, the host RX read strobe drives the RX FIFO read, the transmitter read strobe drives the TX FIFO read, and the host read data and tag come from the RX FIFO. Each FIFO write is suppressed while that FIFO reports full.
- R7: In receive-to-transmit loopback without swap, each receiver byte is written with its unchanged tag to the TX FIFO as well as the RX FIFO, and host TX writes are dropped.
- R8: In receive-to-transmit loopback, the TX FIFO write depends only on the TX FIFO full flag and is still issued when the RX FIFO is full.
- R9: In FIFO swap mode, a host TX write with its data and tag becomes an RX FIFO write, receiver bytes are dropped, and the host RX read strobe drives the TX FIFO read. The host read data and tag come from the TX FIFO, and the transmitter read strobe is blocked.
- R10: FIFO swap takes precedence over receive-to-transmit loopback: no TX FIFO write is issued while swap is set.
- R11: `rx_ser_o` equals `tx_ser_i` when transmit-to-receive loopback is set and both `rx_en_i` and `tx_en_i` are high. Otherwise it equals `line_rx_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ctrl_wr_i | input | 1 | Control register write strobe |
| ctrl_wdata_i | input | CTRL_W | Control write data |
| ctrl_rdata_o | output | CTRL_W | Control register readback |
| soft_rst_o | output | 1 | Sticky soft reset to the controller |
| rx_en_i | input | 1 | Receiver enable |
| tx_en_i | input | 1 | Transmitter enable |
| rcv_valid_i | input | 1 | Receiver delivers a byte |
| rcv_data_i | input | DATA_W | Receiver byte |
| rcv_tag_i | input | TAG_W | Receiver end-of-packet/status tag |
| host_txw_i | input | 1 | Host TX FIFO write strobe |
| host_wdata_i | input | DATA_W | Host write data |
| host_wtag_i | input | TAG_W | Host write tag |
| host_rxr_i | input | 1 | Host RX FIFO read strobe |
| host_rdata_o | output | DATA_W | Data returned to the host |
| host_rtag_o | output | TAG_W | Tag returned to the host |
| xmt_rd_i | input | 1 | Transmitter TX FIFO read strobe |
| rxf_full_i | input | 1 | RX FIFO full |
| rxf_wr_o | output | 1 | RX FIFO write |
| rxf_wdata_o | output | DATA_W | RX FIFO write data |
| rxf_wtag_o | output | TAG_W | RX FIFO write tag |
| rxf_rd_o | output | 1 | RX FIFO read |
| rxf_rdata_i | input | DATA_W | RX FIFO output data |
| rxf_rtag_i | input | TAG_W | RX FIFO output tag |
| txf_full_i | input | 1 | TX FIFO full |
| txf_wr_o | output | 1 | TX FIFO write |
| txf_wdata_o | output | DATA_W | TX FIFO write data |
| txf_wtag_o | output | TAG_W | TX FIFO write tag |
| txf_rd_o | output | 1 | TX FIFO read |
| txf_rdata_i | input | DATA_W | TX FIFO output data |
| txf_rtag_i | input | TAG_W | TX FIFO output tag |
| line_rx_i | input | 1 | Serial receive bit from the line |
| tx_ser_i | input | 1 | Serial transmit bit from the transmitter |
| rx_ser_o | output | 1 | Serial bit fed to the receiver |

## Verification
The bench uses the default build: 8-bit data, 2-bit tags, an 8-bit control register and a zero-write run of two. With these values, all eight mode combinations can be crossed with every one of the 1024 patterns of the ten strobe, full, enable and serial inputs. This covers every steering precedence and full-flag interaction. A run of two keeps the soft-reset release and restart orderings short enough to walk through one by one, including idle gaps and dropped reserved-bit writes between the zero writes.

// File: rtl/hdlc_tst_pkg.sv
package hdlc_tst_pkg;
  localparam int unsigned BIT_SRST = 0;
  localparam int unsigned BIT_RT   = 1;
  localparam int unsigned BIT_TR   = 2;
  localparam int unsigned BIT_SWAP = 3;
  localparam int unsigned MODE_LSB = 1;
  localparam int unsigned USED_W   = 4;

  typedef struct packed {
    logic swap;
    logic tr_loop;
    logic rt_loop;
  } mode_t;
endpackage

// File: rtl/hdlc_tst_rst_sync.sv
module hdlc_tst_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= 1'b1;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[g] <= 1'b0;
          else        chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign rst_q_n = chain_q[STAGES-1];
endmodule

// File: rtl/hdlc_tst_ctrl.sv
module hdlc_tst_ctrl
  import hdlc_tst_pkg::*;
#(
  parameter int unsigned CTRL_W      = 8,
  parameter int unsigned ZERO_WRITES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic [CTRL_W-1:0] wdata_i,
  output logic [CTRL_W-1:0] rdata_o,
  output logic              srst_o,
  output mode_t             mode_o
);
  localparam int unsigned ZC_W  = $clog2(ZERO_WRITES + 1);
  localparam int unsigned RSV_W = CTRL_W - USED_W;
  localparam logic [ZC_W-1:0] ZC_LAST = ZC_W'(ZERO_WRITES - 1);

  logic            srst_q, srst_d;
  logic [ZC_W-1:0] zcnt_q, zcnt_d;
  mode_t           mode_q, mode_d;
  logic            accept;
  logic            upd_en;
  logic            rsv_hit;

  assign rsv_hit = |wdata_i[CTRL_W-1:USED_W];
  assign accept  = wr_i && !rsv_hit;
  assign upd_en  = accept;

  always_comb begin
    srst_d = srst_q;
    zcnt_d = zcnt_q;
    mode_d = mode_q;
    if (wdata_i[BIT_SRST]) begin
      srst_d = 1'b1;
      zcnt_d = '0;
      mode_d = '0;
    end else if (srst_q) begin
      if (zcnt_q == ZC_LAST) begin
        srst_d = 1'b0;
        zcnt_d = '0;
      end else begin
        zcnt_d = zcnt_q + 1'b1;
      end
    end else begin
      mode_d.rt_loop = wdata_i[BIT_RT];
      mode_d.tr_loop = wdata_i[BIT_TR];
      mode_d.swap    = wdata_i[BIT_SWAP];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0;
      zcnt_q <= '0;
      mode_q <= '0;
    end else if (upd_en) begin
      srst_q <= srst_d;
      zcnt_q <= zcnt_d;
      mode_q <= mode_d;
    end
  end

  assign srst_o  = srst_q;
  assign mode_o  = mode_q;
  assign rdata_o = {{RSV_W{1'b0}}, mode_q.swap, mode_q.tr_loop, mode_q.rt_loop, srst_q};
endmodule

// File: rtl/hdlc_tst_steer.sv
module hdlc_tst_steer
  import hdlc_tst_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TAG_W  = 2
) (
  input  logic              srst_i,
  input  mode_t             mode_i,
  input  logic              rcv_valid_i,
  input  logic [DATA_W-1:0] rcv_data_i,
  input  logic [TAG_W-1:0]  rcv_tag_i,
  input  logic              host_txw_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic [TAG_W-1:0]  host_wtag_i,
  input  logic              host_rxr_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic [TAG_W-1:0]  host_rtag_o,
  input  logic              xmt_rd_i,
  input  logic              rxf_full_i,
  output logic              rxf_wr_o,
  output logic [DATA_W-1:0] rxf_wdata_o,
  output logic [TAG_W-1:0]  rxf_wtag_o,
  output logic              rxf_rd_o,
  input  logic [DATA_W-1:0] rxf_rdata_i,
  input  logic [TAG_W-1:0]  rxf_rtag_i,
  input  logic              txf_full_i,
  output logic              txf_wr_o,
  output logic [DATA_W-1:0] txf_wdata_o,
  output logic [TAG_W-1:0]  txf_wtag_o,
  output logic              txf_rd_o,
  input  logic [DATA_W-1:0] txf_rdata_i,
  input  logic [TAG_W-1:0]  txf_rtag_i
);
  logic live;
  logic rx_req, tx_req;

  assign live = !srst_i;

  always_comb begin
    // RX FIFO write side: host in swap mode, receiver otherwise
    if (mode_i.swap) begin
      rx_req      = host_txw_i;
      rxf_wdata_o = host_wdata_i;
      rxf_wtag_o  = host_wtag_i;
    end else begin
      rx_req      = rcv_valid_i;
      rxf_wdata_o = rcv_data_i;
      rxf_wtag_o  = rcv_tag_i;
    end

    // TX FIFO write side: receiver copy in loopback, host otherwise
    if (mode_i.rt_loop) begin
      tx_req      = rcv_valid_i;
      txf_wdata_o = rcv_data_i;
      txf_wtag_o  = rcv_tag_i;
    end else begin
      tx_req      = host_txw_i;
      txf_wdata_o = host_wdata_i;
      txf_wtag_o  = host_wtag_i;
    end

    rxf_wr_o = live && rx_req && !rxf_full_i;
    txf_wr_o = live && tx_req && !txf_full_i && !mode_i.swap;

    // Read side
    if (mode_i.swap) begin
      rxf_rd_o     = 1'b0;
      txf_rd_o     = live && host_rxr_i;
      host_rdata_o = txf_rdata_i;
      host_rtag_o  = txf_rtag_i;
    end else begin
      rxf_rd_o     = live && host_rxr_i;
      txf_rd_o     = live && xmt_rd_i;
      host_rdata_o = rxf_rdata_i;
      host_rtag_o  = rxf_rtag_i;
    end
  end
endmodule

// File: rtl/hdlc_tst_ser_sel.sv
module hdlc_tst_ser_sel (
  input  logic tr_loop_i,
  input  logic rx_en_i,
  input  logic tx_en_i,
  input  logic line_rx_i,
  input  logic tx_ser_i,
  output logic rx_ser_o
);
  logic loop_act;

  assign loop_act = tr_loop_i && rx_en_i && tx_en_i;
  assign rx_ser_o = loop_act ? tx_ser_i : line_rx_i;
endmodule

// File: rtl/hdlc_tst_router.sv
module hdlc_tst_router
  import hdlc_tst_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned TAG_W       = 2,
  parameter int unsigned CTRL_W      = 8,
  parameter int unsigned ZERO_WRITES = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr_i,
  input  logic [CTRL_W-1:0] ctrl_wdata_i,
  output logic [CTRL_W-1:0] ctrl_rdata_o,
  output logic              soft_rst_o,
  input  logic              rx_en_i,
  input  logic              tx_en_i,
  input  logic              rcv_valid_i,
  input  logic [DATA_W-1:0] rcv_data_i,
  input  logic [TAG_W-1:0]  rcv_tag_i,
  input  logic              host_txw_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  input  logic [TAG_W-1:0]  host_wtag_i,
  input  logic              host_rxr_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic [TAG_W-1:0]  host_rtag_o,
  input  logic              xmt_rd_i,
  input  logic              rxf_full_i,
  output logic              rxf_wr_o,
  output logic [DATA_W-1:0] rxf_wdata_o,
  output logic [TAG_W-1:0]  rxf_wtag_o,
  output logic              rxf_rd_o,
  input  logic [DATA_W-1:0] rxf_rdata_i,
  input  logic [TAG_W-1:0]  rxf_rtag_i,
  input  logic              txf_full_i,
  output logic              txf_wr_o,
  output logic [DATA_W-1:0] txf_wdata_o,
  output logic [TAG_W-1:0]  txf_wtag_o,
  output logic              txf_rd_o,
  input  logic [DATA_W-1:0] txf_rdata_i,
  input  logic [TAG_W-1:0]  txf_rtag_i,
  input  logic              line_rx_i,
  input  logic              tx_ser_i,
  output logic              rx_ser_o
);
  logic  rst_sync_n;
  logic  srst;
  mode_t mode;

  hdlc_tst_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_q_n (rst_sync_n)
  );

  hdlc_tst_ctrl #(.CTRL_W(CTRL_W), .ZERO_WRITES(ZERO_WRITES)) i_ctrl (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_i    (ctrl_wr_i),
    .wdata_i (ctrl_wdata_i),
    .rdata_o (ctrl_rdata_o),
    .srst_o  (srst),
    .mode_o  (mode)
  );

  hdlc_tst_steer #(.DATA_W(DATA_W), .TAG_W(TAG_W)) i_steer (
    .srst_i       (srst),
    .mode_i       (mode),
    .rcv_valid_i  (rcv_valid_i),
    .rcv_data_i   (rcv_data_i),
    .rcv_tag_i    (rcv_tag_i),
    .host_txw_i   (host_txw_i),
    .host_wdata_i (host_wdata_i),
    .host_wtag_i  (host_wtag_i),
    .host_rxr_i   (host_rxr_i),
    .host_rdata_o (host_rdata_o),
    .host_rtag_o  (host_rtag_o),
    .xmt_rd_i     (xmt_rd_i),
    .rxf_full_i   (rxf_full_i),
    .rxf_wr_o     (rxf_wr_o),
    .rxf_wdata_o  (rxf_wdata_o),
    .rxf_wtag_o   (rxf_wtag_o),
    .rxf_rd_o     (rxf_rd_o),
    .rxf_rdata_i  (rxf_rdata_i),
    .rxf_rtag_i   (rxf_rtag_i),
    .txf_full_i   (txf_full_i),
    .txf_wr_o     (txf_wr_o),
    .txf_wdata_o  (txf_wdata_o),
    .txf_wtag_o   (txf_wtag_o),
    .txf_rd_o     (txf_rd_o),
    .txf_rdata_i  (txf_rdata_i),
    .txf_rtag_i   (txf_rtag_i)
  );

  hdlc_tst_ser_sel i_ser_sel (
    .tr_loop_i (mode.tr_loop),
    .rx_en_i   (rx_en_i),
    .tx_en_i   (tx_en_i),
    .line_rx_i (line_rx_i),
    .tx_ser_i  (tx_ser_i),
    .rx_ser_o  (rx_ser_o)
  );

  assign soft_rst_o = srst;
endmodule

// File: rtl/hdlc_tst_router_chk.sv
module hdlc_tst_router_chk #(
  parameter int unsigned CTRL_W = 8
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              ctrl_wr_i,
  input logic [CTRL_W-1:0] ctrl_wdata_i,
  input logic [CTRL_W-1:0] ctrl_rdata_o,
  input logic              soft_rst_o,
  input logic              rx_en_i,
  input logic              tx_en_i,
  input logic              rcv_valid_i,
  input logic              rxf_wr_o,
  input logic              rxf_rd_o,
  input logic              txf_full_i,
  input logic              txf_wr_o,
  input logic              txf_rd_o,
  input logic              line_rx_i,
  input logic              tx_ser_i,
  input logic              rx_ser_o
);
  logic rsv_clean;
  assign rsv_clean = ctrl_wdata_i[CTRL_W-1:4] == '0;

  assert_srst_quiet_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    soft_rst_o |-> !(rxf_wr_o || txf_wr_o || rxf_rd_o || txf_rd_o));

  assert_srst_set_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctrl_wr_i && ctrl_wdata_i[0] && rsv_clean) |=> soft_rst_o);

  assert_srst_release_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(soft_rst_o) |-> $past(ctrl_wr_i && !ctrl_wdata_i[0] && rsv_clean));

  assert_rsv_zero_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    ctrl_rdata_o[CTRL_W-1:4] == '0);

  assert_rt_copy_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (ctrl_rdata_o[1] && !ctrl_rdata_o[3] && !soft_rst_o && rcv_valid_i && !txf_full_i)
      |-> txf_wr_o);

  assert_swap_no_txw_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    ctrl_rdata_o[3] |-> !txf_wr_o);

  assert_ser_loop_R11: assert property (@(posedge clk) disable iff (!rst_q_n)
    rx_ser_o == ((ctrl_rdata_o[2] && rx_en_i && tx_en_i) ? tx_ser_i : line_rx_i));
endmodule

bind hdlc_tst_router hdlc_tst_router_chk #(.CTRL_W(CTRL_W)) i_chk (
  .rst_q_n (rst_sync_n),
  .*
);

// File: tb/test_hdlc_tst_router.sv
`timescale 1ns/1ps
module test_hdlc_tst_router;
  localparam int DW = 8;
  localparam int TW = 2;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic ctrl_wr_i;
  logic [CW-1:0] ctrl_wdata_i, ctrl_rdata_o;
  logic soft_rst_o, rx_en_i, tx_en_i;
  logic rcv_valid_i, host_txw_i, host_rxr_i, xmt_rd_i, rxf_full_i, txf_full_i;
  logic [DW-1:0] rcv_data_i, host_wdata_i, host_rdata_o, rxf_wdata_o, rxf_rdata_i, txf_wdata_o, txf_rdata_i;
  logic [TW-1:0] rcv_tag_i, host_wtag_i, host_rtag_o, rxf_wtag_o, rxf_rtag_i, txf_wtag_o, txf_rtag_i;
  logic rxf_wr_o, rxf_rd_o, txf_wr_o, txf_rd_o;
  logic line_rx_i, tx_ser_i, rx_ser_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hdlc_tst_router i_hdlc_tst_router (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ctrl_write(input logic [CW-1:0] v);
    @(negedge clk);
    ctrl_wr_i = 1'b1;
    ctrl_wdata_i = v;
    @(negedge clk);
    ctrl_wr_i = 1'b0;
    ctrl_wdata_i = '0;
  endtask

  task automatic apply(input int s);
    rcv_valid_i  = s[0];
    host_txw_i   = s[1];
    host_rxr_i   = s[2];
    xmt_rd_i     = s[3];
    rxf_full_i   = s[4];
    txf_full_i   = s[5];
    rx_en_i      = s[6];
    tx_en_i      = s[7];
    line_rx_i    = s[8];
    tx_ser_i     = s[9];
    rcv_data_i   = 8'(s) ^ 8'h5A;
    rcv_tag_i    = 2'(s >> 8);
    host_wdata_i = ~8'(s);
    host_wtag_i  = 2'(s) ^ 2'b11;
    rxf_rdata_i  = 8'(s) + 8'h11;
    rxf_rtag_i   = 2'(s >> 2);
    txf_rdata_i  = 8'(s) + 8'h77;
    txf_rtag_i   = 2'(s >> 4);
  endtask

  // Expected steering computed from R6..R11 with mode bits rt, tr, sw and soft reset sr
  task automatic check_steer(input int s, input bit rt, input bit tr, input bit sw, input bit sr);
    bit e_rxw, e_txw, e_rxr, e_txr, e_ser;
    e_rxw = !sr && !s[4] && (sw ? s[1] : s[0]);
    e_txw = !sr && !s[5] && !sw && (rt ? s[0] : s[1]);
    e_rxr = !sr && !sw && s[2];
    e_txr = !sr && (sw ? s[2] : s[3]);
    e_ser = (tr && s[6] && s[7]) ? s[9] : s[8];
    if (sr) begin
      chk("R2 strobes in soft reset", {rxf_wr_o, txf_wr_o, rxf_rd_o, txf_rd_o}, 0);
    end else if (sw) begin
      chk("R9 rxf_wr swap", rxf_wr_o, e_rxw);
      chk("R10 txf_wr swap", txf_wr_o, 0);
      chk("R9 rxf_rd swap", rxf_rd_o, 0);
      chk("R9 txf_rd swap", txf_rd_o, e_txr);
      chk("R9 host read data", {host_rtag_o, host_rdata_o}, {2'(s >> 4), 8'(s) + 8'h77});
      if (e_rxw) chk("R9 rxf data", {rxf_wtag_o, rxf_wdata_o}, {2'(s) ^ 2'b11, ~8'(s)});
    end else begin
      chk(rt ? "R8 rxf_wr" : "R6 rxf_wr", rxf_wr_o, e_rxw);
      chk(rt ? "R8 txf_wr" : "R6 txf_wr", txf_wr_o, e_txw);
      chk("R6 rxf_rd", rxf_rd_o, e_rxr);
      chk("R6 txf_rd", txf_rd_o, e_txr);
      chk("R6 host read data", {host_rtag_o, host_rdata_o}, {2'(s >> 2), 8'(s) + 8'h11});
      if (e_rxw) chk("R6 rxf data", {rxf_wtag_o, rxf_wdata_o}, {2'(s >> 8), 8'(s) ^ 8'h5A});
      if (e_txw && rt) chk("R7 txf data", {txf_wtag_o, txf_wdata_o}, {2'(s >> 8), 8'(s) ^ 8'h5A});
      if (e_txw && !rt) chk("R6 txf data", {txf_wtag_o, txf_wdata_o}, {2'(s) ^ 2'b11, ~8'(s)});
    end
    chk("R11 rx_ser", rx_ser_o, e_ser);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    ctrl_wr_i = 1'b0;
    ctrl_wdata_i = '0;
    apply(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    chk("R1 readback after reset", ctrl_rdata_o, 0);
    chk("R1 soft reset low", soft_rst_o, 0);

    // R4: reserved bits dropped and read zero
    ctrl_write(8'hF2);
    chk("R4 reserved write dropped", ctrl_rdata_o, 0);
    ctrl_write(8'h1A);
    chk("R4 reserved write dropped", ctrl_rdata_o, 0);
    ctrl_write(8'h0E);
    chk("R5 mode readback", ctrl_rdata_o, 8'h0E);

    // R2 / R3 sticky soft reset sequence
    ctrl_write(8'h01);
    chk("R2 soft reset set", soft_rst_o, 1);
    chk("R2 modes cleared", ctrl_rdata_o, 8'h01);
    ctrl_write(8'h0E);
    chk("R3 after one zero write", soft_rst_o, 1);
    chk("R2 modes held zero", ctrl_rdata_o, 8'h01);
    repeat (5) @(negedge clk);
    ctrl_write(8'h00);
    chk("R3 released after two zero writes with idle gap", soft_rst_o, 0);
    chk("R3 modes still zero", ctrl_rdata_o, 0);
    ctrl_write(8'h01);
    ctrl_write(8'h00);
    ctrl_write(8'h03);
    chk("R3 restart keeps reset", soft_rst_o, 1);
    ctrl_write(8'h00);
    chk("R3 one zero after restart", soft_rst_o, 1);
    ctrl_write(8'h80);
    chk("R4 reserved write not counted", soft_rst_o, 1);
    ctrl_write(8'h00);
    chk("R3 released after restart", soft_rst_o, 0);

    // R2: steering quiet during soft reset
    ctrl_write(8'h06);
    ctrl_write(8'h01);
    for (int s = 0; s < 1024; s++) begin
      @(negedge clk);
      apply(s);
      #1;
      check_steer(s, 1'b0, 1'b0, 1'b0, 1'b1);
    end
    ctrl_write(8'h00);
    ctrl_write(8'h00);

    // R5..R11 sweep over all modes and input patterns
    for (int m = 0; m < 8; m++) begin
      ctrl_write(8'(m << 1));
      chk("R5 mode readback", ctrl_rdata_o, 8'(m << 1));
      for (int s = 0; s < 1024; s++) begin
        @(negedge clk);
        apply(s);
        #1;
        check_steer(s, m[0], m[1], m[2], 1'b0);
      end
    end

    // R1: hardware reset clears a set soft reset
    ctrl_write(8'h01);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 hardware reset clears soft reset", soft_rst_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule